// File: doc/BRIEF.md
# Fetch Miss-Stall Controller

This block sits at the front of an instruction fetch pipeline and decides, each cycle, how many instructions the fetch stage may deliver and from which address it continues. It looks at the outcome of the instruction translation lookup and the instruction cache lookup for the group's first access. It reacts to three miss outcomes: a miss with a known latency, a miss whose latency is not yet known, and a request to retry. It also accepts a later completion event that reports the remaining latency of an outstanding miss. A small state machine holds the stall condition, and a down-counter times the stall.

When no miss stall is active, a slot-by-slot limiter walks the fetch group. It ends the group early when the fetch queue runs out of room, when a hold condition is present (unknown branch target, pending trap or pending system call), when the number of predicted-taken branches reaches its limit, or when fetching across cache lines is disabled and a slot leaves the first line. It steps the fetch address from slot to slot, using predicted targets when a predictor is present and reports one. Every cycle it reports a stall reason code for statistics.

The state machine has three states. ST_RUN is fetching. ST_COUNT means the counter is non-zero and draining. ST_BLOCK means fetch waits for a completion event. The transitions are as follows:
- ST_RUN to ST_COUNT on a known-latency miss.
- ST_RUN to ST_BLOCK on an unknown-latency miss.
- ST_RUN stays in ST_RUN on retry.
- ST_COUNT to ST_RUN when the counter reaches zero.
- ST_BLOCK to ST_COUNT on a completion with a non-zero latency.
- ST_BLOCK to ST_RUN on a completion with zero latency.
- Any state loads the counter from a completion event.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. Reset sets the fetch PC to RESET_PC (0) and the state to ST_RUN. A PC load request replaces the fetch PC at the next edge and takes priority over the advance of a fetched group.
- R2: Access status encoding is 0 known, 1 unknown and 2 retry.
  - The translation lookup misses when its status is not known or its latency exceeds 1.
  - The cache lookup misses when its status is not known or its latency exceeds HIT_LAT.
  - The translation outcome is checked first.
  - A miss delivers 0 instructions with stall reason 1 (miss).
- R3: A known-latency miss of latency L adds L-1 further stalled cycles, for L stalled cycles in total, before fetch resumes.
- R4: An unknown-latency miss stalls fetch (0 instructions, reason 1) in every cycle until a completion event arrives.
- R5: A completion event with latency L ends a block. Fetch then stays stalled for L further cycles, and resumes in the next cycle when L is 0. A completion event loads the counter in any state and takes priority over a miss in the same cycle.
- R6: A retry status stalls only the current cycle and leaves no block and no countdown.
- R7: With no limit active, W instructions are delivered from consecutive addresses spaced ISZ apart, with stall reason 0.
- R8: The group holds at most as many instructions as the fetch queue has free entries. A cut caused by this limit reports stall reason 3.
- R9: An unknown target, a pending trap or a pending system call delivers 0 instructions with stall reason 4. In that cycle the access statuses are ignored, so no miss state results.
- R10: After BR_LIMIT predicted-taken branches in a group, no further slot is fetched, and the stall reason is 5.
- R11: With cross-line fetch disabled, a slot after the first whose address lies outside the first slot's cache line ends the group with stall reason 2. With cross-line fetch enabled, no such cut happens.
- R12: Each slot's successor address is its predicted target only when a predictor is present, the slot is a control instruction and the predictor reports a target. In every other case the successor address is PC+ISZ. After a non-empty group, the fetch PC moves to the successor of the last fetched slot, and after an empty group it stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_load | input | 1 | Replace the fetch PC at the next edge |
| pc_load_addr | input | AW | New fetch PC |
| tlb_status | input | 2 | Translation lookup status (0 known, 1 unknown, 2 retry) |
| tlb_lat | input | LW | Translation lookup latency |
| ic_status | input | 2 | Cache lookup status (0 known, 1 unknown, 2 retry) |
| ic_lat | input | LW | Cache lookup latency |
| done_valid | input | 1 | Completion event for an outstanding miss |
| done_lat | input | LW | Remaining latency reported by the completion |
| q_free | input | CW | Free entries in the fetch queue |
| tgt_unknown | input | 1 | An unresolved branch target is outstanding |
| trap_pend | input | 1 | A trap waits to commit |
| sys_pend | input | 1 | A system call waits to commit |
| multi_line | input | 1 | Allow a group to span cache lines |
| pred_on | input | 1 | A branch predictor is present |
| slot_ctrl | input | W | Slot i holds a control instruction |
| slot_hit | input | W | The predictor reports a target for slot i |
| slot_tgt | input | W*AW | Predicted target of slot i in bits [i*AW +: AW] |
| fetch_pc | output | AW | Current fetch PC |
| fetch_cnt | output | CW | Instructions delivered this cycle |
| stall_why | output | 3 | 0 none, 1 miss, 2 line, 3 queue, 4 hold, 5 branch limit |

## Verification
The group limiter is tested with three sets of inputs:
- Plain sequential groups, which expose the full width.
- A group started two slots before a line boundary. Run once with cross-line fetch off and once with it on, this separates the line cut from the width cut.
- A small queue-free count together with predicted-taken targets, which separates the queue cut from the branch-limit cut. One slot's predictor reports no target, which shows that only reported targets redirect.

The miss path is tested with each outcome from each source:
- A known miss from the translation lookup and a known miss from the cache lookup. The cycle in which fetch resumes separates L from L-1 stall cycles.
- An unknown miss released by completions of non-zero and zero latency.
- A retry, which shows that no stall remains afterwards.
- A translation miss combined with a cache unknown status, which shows that the translation outcome is checked first.
- A completion while running, and an unknown status during a hold, which shows that the status is ignored in that cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [1:0] {
        MS_KNOWN   = 2'd0,
        MS_UNKNOWN = 2'd1,
        MS_RETRY   = 2'd2
    } mem_st_e;

    typedef enum logic [2:0] {
        FS_NONE   = 3'd0,
        FS_MISS   = 3'd1,
        FS_ALIGN  = 3'd2,
        FS_QFULL  = 3'd3,
        FS_HOLD   = 3'd4,
        FS_BRANCH = 3'd5
    } stall_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_COUNT = 2'd1,
        ST_BLOCK = 2'd2
    } fsm_e;
endpackage

// File: rtl/fsc_miss_class.sv
module fsc_miss_class
    import fsc_pkg::*;
#(
    parameter int LW      = 8,
    parameter int HIT_LAT = 1
) (
    input  logic [1:0]    tlb_st,
    input  logic [LW-1:0] tlb_lat,
    input  logic [1:0]    ic_st,
    input  logic [LW-1:0] ic_lat,
    output logic          miss,
    output mem_st_e       kind,
    output logic [LW-1:0] lat
);
    logic tlb_miss, ic_miss;

    function automatic mem_st_e to_kind(input logic [1:0] s);
        if (s == MS_KNOWN)        return MS_KNOWN;
        else if (s == MS_UNKNOWN) return MS_UNKNOWN;
        else                      return MS_RETRY;
    endfunction

    always_comb begin
        tlb_miss = (tlb_lat > LW'(1)) || (tlb_st != MS_KNOWN);
        ic_miss  = (ic_lat > LW'(HIT_LAT)) || (ic_st != MS_KNOWN);
        miss     = tlb_miss || ic_miss;
        if (tlb_miss) begin
            kind = to_kind(tlb_st);
            lat  = tlb_lat;
        end else begin
            kind = to_kind(ic_st);
            lat  = ic_lat;
        end
    end
endmodule

// File: rtl/fsc_group_limit.sv
module fsc_group_limit
    import fsc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int W        = 4,
    parameter int CW       = 3,
    parameter int ISZ      = 4,
    parameter int LINE_B   = 32,
    parameter int BR_LIMIT = 2
) (
    input  logic [AW-1:0]   base_pc,
    input  logic [CW-1:0]   q_free,
    input  logic            hold,
    input  logic            multi_line,
    input  logic            pred_on,
    input  logic [W-1:0]    slot_ctrl,
    input  logic [W-1:0]    slot_hit,
    input  logic [W*AW-1:0] slot_tgt,
    output logic [CW-1:0]   grp_cnt,
    output stall_e          end_why,
    output logic [AW-1:0]   next_pc
);
    localparam int LB = $clog2(LINE_B);

    logic [AW-1:0] pc_s [W+1];
    logic [CW-1:0] br_s [W+1];
    logic          go_s [W+1];
    logic [W-1:0]  take, blk_q, blk_b, blk_a;

    assign pc_s[0] = base_pc;
    assign br_s[0] = '0;
    assign go_s[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_slot
        logic [AW-1:0] seq_pc, tgt;
        logic          taken;
        assign seq_pc = pc_s[i] + AW'(ISZ);
        assign tgt    = slot_tgt[i*AW +: AW];
        assign taken  = pred_on && slot_ctrl[i] && slot_hit[i] && (tgt != seq_pc);
        assign pc_s[i+1] = taken ? tgt : seq_pc;
        assign br_s[i+1] = br_s[i] + {{(CW-1){1'b0}}, taken};
        assign blk_q[i]  = (q_free <= CW'(i));
        assign blk_b[i]  = (int'(br_s[i]) >= BR_LIMIT);
        if (i == 0) begin : g_first
            assign blk_a[i] = 1'b0;
        end else begin : g_rest
            assign blk_a[i] = !multi_line && (pc_s[i][AW-1:LB] != base_pc[AW-1:LB]);
        end
        assign take[i]   = go_s[i] && !blk_q[i] && !hold && !blk_b[i] && !blk_a[i];
        assign go_s[i+1] = take[i];
    end

    always_comb begin
        grp_cnt = '0;
        next_pc = base_pc;
        end_why = FS_NONE;
        for (int i = 0; i < W; i++) begin
            if (take[i]) begin
                grp_cnt = grp_cnt + CW'(1);
                next_pc = pc_s[i+1];
            end else if (go_s[i]) begin
                if (blk_q[i])      end_why = FS_QFULL;
                else if (hold)     end_why = FS_HOLD;
                else if (blk_b[i]) end_why = FS_BRANCH;
                else               end_why = FS_ALIGN;
            end
        end
    end
endmodule

// File: rtl/fsc_stall_fsm.sv
module fsc_stall_fsm
    import fsc_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          try_miss,
    input  mem_st_e       kind,
    input  logic [LW-1:0] lat,
    input  logic          done_v,
    input  logic [LW-1:0] done_lat,
    output fsm_e          state,
    output logic [LW-1:0] cnt,
    output logic          stalled
);
    fsm_e          nxt;
    logic [LW-1:0] cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (done_v) begin
            cnt_nxt = done_lat;
            nxt     = (done_lat != '0) ? ST_COUNT : ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (try_miss && kind == MS_KNOWN) begin
                        cnt_nxt = lat - LW'(1);
                        nxt     = (lat > LW'(1)) ? ST_COUNT : ST_RUN;
                    end else if (try_miss && kind == MS_UNKNOWN) begin
                        nxt = ST_BLOCK;
                    end
                end
                ST_COUNT: begin
                    cnt_nxt = cnt - LW'(1);
                    if (cnt == LW'(1)) nxt = ST_RUN;
                end
                ST_BLOCK: nxt = ST_BLOCK;
                default:  nxt = ST_RUN;
            endcase
        end
    end

    always_comb begin
        stalled = (state != ST_RUN);
    end
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl
    import fsc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          W        = 4,
    parameter int          LW       = 8,
    parameter int          ISZ      = 4,
    parameter int          LINE_B   = 32,
    parameter int          HIT_LAT  = 1,
    parameter int          BR_LIMIT = 2,
    parameter logic [31:0] RESET_PC = 32'h0,
    localparam int         CW       = $clog2(W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_load,
    input  logic [AW-1:0]   pc_load_addr,
    input  logic [1:0]      tlb_status,
    input  logic [LW-1:0]   tlb_lat,
    input  logic [1:0]      ic_status,
    input  logic [LW-1:0]   ic_lat,
    input  logic            done_valid,
    input  logic [LW-1:0]   done_lat,
    input  logic [CW-1:0]   q_free,
    input  logic            tgt_unknown,
    input  logic            trap_pend,
    input  logic            sys_pend,
    input  logic            multi_line,
    input  logic            pred_on,
    input  logic [W-1:0]    slot_ctrl,
    input  logic [W-1:0]    slot_hit,
    input  logic [W*AW-1:0] slot_tgt,
    output logic [AW-1:0]   fetch_pc,
    output logic [CW-1:0]   fetch_cnt,
    output logic [2:0]      stall_why
);
    logic          mc_miss, try_miss, stalled;
    mem_st_e       mc_kind;
    logic [LW-1:0] mc_lat, dly_cnt;
    logic [CW-1:0] lim_cnt;
    stall_e        lim_why;
    logic [AW-1:0] lim_npc;
    fsm_e          fsm_st;

    fsc_miss_class #(.LW(LW), .HIT_LAT(HIT_LAT)) u_class (
        .tlb_st(tlb_status), .tlb_lat(tlb_lat),
        .ic_st(ic_status), .ic_lat(ic_lat),
        .miss(mc_miss), .kind(mc_kind), .lat(mc_lat)
    );

    fsc_group_limit #(
        .AW(AW), .W(W), .CW(CW), .ISZ(ISZ), .LINE_B(LINE_B), .BR_LIMIT(BR_LIMIT)
    ) u_limit (
        .base_pc(fetch_pc), .q_free(q_free),
        .hold(tgt_unknown || trap_pend || sys_pend),
        .multi_line(multi_line), .pred_on(pred_on),
        .slot_ctrl(slot_ctrl), .slot_hit(slot_hit), .slot_tgt(slot_tgt),
        .grp_cnt(lim_cnt), .end_why(lim_why), .next_pc(lim_npc)
    );

    assign try_miss = !stalled && (lim_cnt != '0) && mc_miss;

    fsc_stall_fsm #(.LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .try_miss(try_miss), .kind(mc_kind), .lat(mc_lat),
        .done_v(done_valid), .done_lat(done_lat),
        .state(fsm_st), .cnt(dly_cnt), .stalled(stalled)
    );

    always_comb begin
        if (stalled || try_miss) begin
            fetch_cnt = '0;
            stall_why = FS_MISS;
        end else begin
            fetch_cnt = lim_cnt;
            stall_why = lim_why;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               fetch_pc <= AW'(RESET_PC);
        else if (pc_load)         fetch_pc <= pc_load_addr;
        else if (fetch_cnt != '0) fetch_pc <= lim_npc;
    end
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk
    import fsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int W  = 4,
    parameter int LW = 8,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    state,
    input logic [LW-1:0] cnt,
    input logic          try_miss,
    input logic [1:0]    miss_kind,
    input logic [LW-1:0] miss_lat,
    input logic          done_valid,
    input logic [LW-1:0] done_lat,
    input logic          pc_load,
    input logic [AW-1:0] fetch_pc,
    input logic [CW-1:0] fetch_cnt,
    input logic [2:0]    stall_why
);
    // R4
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK) |-> (fetch_cnt == '0 && stall_why == FS_MISS));

    // R3
    known_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (try_miss && miss_kind == MS_KNOWN && !done_valid)
        |=> (cnt == $past(miss_lat - LW'(1))));

    // R4
    unknown_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (try_miss && miss_kind == MS_UNKNOWN && !done_valid) |=> (state == ST_BLOCK));

    // R5
    done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (cnt == $past(done_lat) && state != ST_BLOCK));

    // R6
    retry_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (try_miss && miss_kind == MS_RETRY && !done_valid)
        |=> (state == ST_RUN && cnt == '0));

    // R7
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fetch_cnt) <= W);

    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cnt == '0 && !pc_load) |=> $stable(fetch_pc));
endmodule

bind fetch_stall_ctrl fsc_chk #(.AW(AW), .W(W), .LW(LW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(fsm_st), .cnt(dly_cnt),
    .try_miss(try_miss), .miss_kind(mc_kind), .miss_lat(mc_lat),
    .done_valid(done_valid), .done_lat(done_lat), .pc_load(pc_load),
    .fetch_pc(fetch_pc), .fetch_cnt(fetch_cnt), .stall_why(stall_why)
);

// File: tb/tb_fetch_stall_ctrl.sv
module tb_fetch_stall_ctrl;
    localparam int AW = 32, W = 4, LW = 8, CW = $clog2(W + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pc_load = 1'b0;
    logic [AW-1:0]   pc_load_addr = '0;
    logic [1:0]      tlb_status = 2'd0, ic_status = 2'd0;
    logic [LW-1:0]   tlb_lat = 8'd1, ic_lat = 8'd1;
    logic            done_valid = 1'b0;
    logic [LW-1:0]   done_lat = '0;
    logic [CW-1:0]   q_free = CW'(4);
    logic            tgt_unknown = 1'b0, trap_pend = 1'b0, sys_pend = 1'b0;
    logic            multi_line = 1'b0, pred_on = 1'b0;
    logic [W-1:0]    slot_ctrl = '0, slot_hit = '0;
    logic [W*AW-1:0] slot_tgt = '0;
    logic [AW-1:0]   fetch_pc;
    logic [CW-1:0]   fetch_cnt;
    logic [2:0]      stall_why;

    always #10 clk = ~clk;

    fetch_stall_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_load_addr(pc_load_addr),
        .tlb_status(tlb_status), .tlb_lat(tlb_lat), .ic_status(ic_status), .ic_lat(ic_lat),
        .done_valid(done_valid), .done_lat(done_lat), .q_free(q_free),
        .tgt_unknown(tgt_unknown), .trap_pend(trap_pend), .sys_pend(sys_pend),
        .multi_line(multi_line), .pred_on(pred_on), .slot_ctrl(slot_ctrl),
        .slot_hit(slot_hit), .slot_tgt(slot_tgt),
        .fetch_pc(fetch_pc), .fetch_cnt(fetch_cnt), .stall_why(stall_why)
    );

    typedef struct {
        int          cnt;
        int          why;
        logic [31:0] pc;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    // driver: push the expectation for the cycle now being driven, then advance
    task automatic cyc(input int c, input int w, input logic [31:0] p, input string tag);
        exp_t e;
        e.cnt = c; e.why = w; e.pc = p; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // monitor: sample late in the cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (int'(fetch_cnt) != e.cnt || int'(stall_why) != e.why || fetch_pc !== e.pc) begin
                    errors++;
                    $display("FAIL %s: act cnt=%0d why=%0d pc=%h exp cnt=%0d why=%0d pc=%h",
                             e.tag, fetch_cnt, stall_why, fetch_pc, e.cnt, e.why, e.pc);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: act running exp done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        cyc(4, 0, 32'h0, "R1 reset pc");
        rst_n = 1'b1;
        pc_load = 1'b1; pc_load_addr = 32'h100;
        cyc(4, 0, 32'h0, "R1 load priority");
        pc_load = 1'b0;
        cyc(4, 0, 32'h100, "R7 full width");
        cyc(4, 0, 32'h110, "R7 full width again");
        pc_load = 1'b1; pc_load_addr = 32'h118; tgt_unknown = 1'b1;
        cyc(0, 4, 32'h120, "R9 unknown target");
        pc_load = 1'b0; tgt_unknown = 1'b0;
        cyc(2, 2, 32'h118, "R11 line cut");
        pc_load = 1'b1; pc_load_addr = 32'h138; trap_pend = 1'b1; multi_line = 1'b1;
        cyc(0, 4, 32'h120, "R9 trap pending");
        pc_load = 1'b0; trap_pend = 1'b0;
        cyc(4, 0, 32'h138, "R11 cross line allowed");
        q_free = CW'(2);
        cyc(2, 3, 32'h148, "R8 queue room 2");
        q_free = CW'(0);
        cyc(0, 3, 32'h150, "R8 queue full");
        q_free = CW'(4); pred_on = 1'b1; slot_ctrl = 4'b0011; slot_hit = 4'b0011;
        slot_tgt[0*AW +: AW] = 32'h200; slot_tgt[1*AW +: AW] = 32'h300;
        cyc(2, 5, 32'h150, "R10 branch limit");
        pred_on = 1'b0;
        cyc(4, 0, 32'h300, "R12 no predictor");
        pred_on = 1'b1; slot_hit = 4'b0010;
        cyc(4, 0, 32'h310, "R12 no target then taken");
        pred_on = 1'b0; slot_ctrl = '0; slot_hit = '0;
        tlb_lat = 8'd3;
        cyc(0, 1, 32'h308, "R2 tlb known miss");
        tlb_lat = 8'd1;
        cyc(0, 1, 32'h308, "R3 countdown 1");
        cyc(0, 1, 32'h308, "R3 countdown 2");
        cyc(4, 0, 32'h308, "R3 resume after L");
        ic_lat = 8'd2;
        cyc(0, 1, 32'h318, "R2 cache known miss");
        ic_lat = 8'd1;
        cyc(0, 1, 32'h318, "R3 cache countdown");
        cyc(4, 0, 32'h318, "R3 cache resume");
        tlb_status = 2'd1;
        cyc(0, 1, 32'h328, "R4 unknown miss");
        tlb_status = 2'd0;
        cyc(0, 1, 32'h328, "R4 blocked 1");
        cyc(0, 1, 32'h328, "R4 blocked 2");
        done_valid = 1'b1; done_lat = 8'd2;
        cyc(0, 1, 32'h328, "R5 completion cycle");
        done_valid = 1'b0;
        cyc(0, 1, 32'h328, "R5 after completion 1");
        cyc(0, 1, 32'h328, "R5 after completion 2");
        cyc(4, 0, 32'h328, "R5 resume");
        ic_status = 2'd2;
        cyc(0, 1, 32'h338, "R6 retry");
        ic_status = 2'd0;
        cyc(4, 0, 32'h338, "R6 no lingering stall");
        tlb_status = 2'd1;
        cyc(0, 1, 32'h348, "R4 unknown again");
        tlb_status = 2'd0; done_valid = 1'b1; done_lat = 8'd0;
        cyc(0, 1, 32'h348, "R5 zero latency completion");
        done_valid = 1'b0;
        cyc(4, 0, 32'h348, "R5 immediate resume");
        tgt_unknown = 1'b1; tlb_status = 2'd1;
        cyc(0, 4, 32'h358, "R9 status ignored during hold");
        tgt_unknown = 1'b0; tlb_status = 2'd0;
        cyc(4, 0, 32'h358, "R9 no block after hold");
        done_valid = 1'b1; done_lat = 8'd1;
        cyc(4, 0, 32'h368, "R5 completion while running");
        done_valid = 1'b0;
        cyc(0, 1, 32'h378, "R5 counted from running");
        cyc(4, 0, 32'h378, "R5 running resume");
        tlb_lat = 8'd3; ic_status = 2'd1;
        cyc(0, 1, 32'h388, "R2 tlb checked first");
        tlb_lat = 8'd1; ic_status = 2'd0;
        cyc(0, 1, 32'h388, "R2 tlb first countdown 1");
        cyc(0, 1, 32'h388, "R2 tlb first countdown 2");
        cyc(4, 0, 32'h388, "R2 tlb first resume");
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule